// File: doc/BRIEF.md
# SAR ADC Conversion Timing Sequencer

This block sequences one conversion of a 10-bit successive-approximation converter. It makes its own ADC clock from the system clock as a pair of one-clock ticks: a rise tick every `DIV` system clocks, and a fall tick half an ADC period after each rise tick. Each conversion runs for a fixed number of ADC cycles. During that time the block pulses a sample-and-hold strobe, walks a trial code from the MSB down to the LSB against an external comparator, then stores the result and raises a sticky completion flag.

Two conversion lengths exist. A normal conversion takes 13 ADC cycles. The first conversion after the block is enabled takes 25 ADC cycles. Software starts a conversion by writing 1 to the start bit. In single mode the start bit drops when the result lands. In free-running mode each completion starts the next conversion and the start bit stays high. The channel/reference select is copied to the analog mux only when a conversion begins.

Top module: `sar_conv_seq`

## Requirements
- R1: After synchronous reset, `start_o`, `done_flag_o`, `sh_strobe_o`, `result_o`, `dac_code_o` and `mux_sel_o` are all zero.
- R2: A rise tick occurs once every `DIV` system clocks. A conversion begins on the first rise tick after the clock edge that set the start bit, so the conversion starts 1 to `DIV` clocks after the write.
- R3: A normal conversion lasts 13 ADC cycles. `done_flag_o` rises 13·DIV+1 to 13·DIV+DIV clocks after the start write. In free-running mode consecutive completions are exactly 13·DIV clocks apart.
- R4: The first conversion after reset, or after `en_i` was low, is extended. `done_flag_o` rises 25·DIV+1 to 25·DIV+DIV clocks after the start write.
- R5: `sh_strobe_o` is a single-clock pulse issued on the fall tick of ADC cycle 2 (normal) or ADC cycle 14 (extended). It therefore comes DIV+DIV/2 clocks after a conversion start, or 13·DIV+DIV/2 clocks after the start of an extended conversion, and 11·DIV+DIV/2 clocks before completion in both cases. It is only ever high while `start_o` is high.
- R6: After the strobe, one result bit is resolved per ADC cycle, MSB first. `dac_code_o` carries the trial code, and a bit is kept at 1 when `comp_i` is 1, meaning input ≥ trial code. For a held input code v, `result_o` equals v.
- R7: In single mode (`free_i`=0) `start_o` falls on the same clock edge on which `done_flag_o` rises.
- R8: In free-running mode (`free_i`=1) the completing rise tick starts the next conversion, and `start_o` stays 1.
- R9: `done_flag_o` stays 1 until a clock with `flag_clr_i`=1. A completion in the same clock takes priority over the clear.
- R10: A start write with data 0 (`start_wr_i`=1, `start_wd_i`=0) changes neither `start_o` nor a conversion in progress.
- R11: While `en_i`=0, any conversion is aborted, `start_o` is held at 0, start writes are ignored and no completion occurs. The next conversion after re-enabling is extended.
- R12: `mux_sel_o` takes the value of `sel_i` only on the rise tick that begins a conversion. A change of `sel_i` during a conversion appears only at the next conversion start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Converter enable level |
| free_i | input | 1 | 1 = free-running mode, 0 = single mode |
| sel_i | input | SEL_W | Channel/reference select requested by software |
| start_wr_i | input | 1 | Write strobe for the start bit |
| start_wd_i | input | 1 | Data written to the start bit (only 1 acts) |
| flag_clr_i | input | 1 | Clears the completion flag (write-1-to-clear) |
| comp_i | input | 1 | Comparator: 1 when held input ≥ `dac_code_o` |
| sh_strobe_o | output | 1 | Sample-and-hold pulse |
| dac_code_o | output | RES_W | Trial code for the DAC |
| result_o | output | RES_W | Result of the last completed conversion |
| done_flag_o | output | 1 | Sticky completion flag |
| start_o | output | 1 | Start bit read back |
| mux_sel_o | output | SEL_W | Select latched at conversion start |

## Verification
Errors in the ADC cycle counter or in the extended-conversion marker show up at the ports within one conversion. Either the completion lands outside a window one ADC period wide, or the strobe-to-completion distance moves off 11.5 ADC periods. A wrong bit index or comparator polarity in the approximation register corrupts `result_o` at the next completion, so the bench sweeps every input code in free-running mode. A missed clear of the start bit or of the extended marker after an abort shows up at the next completion, as a wrong `start_o` level or an early flag.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  // ADC cycle (1-based) whose falling phase samples in a normal conversion
  localparam int NORM_SAMPLE = 2;

  typedef struct packed {
    logic rise;
    logic fall;
  } adc_tick_t;

  // extended conversions keep the same tail after sampling as normal ones
  function automatic int ext_sample_cycle(input int norm_cyc, input int ext_cyc);
    return ext_cyc - norm_cyc + NORM_SAMPLE;
  endfunction

endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen
  import sar_seq_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic      clk,
  input  logic      rst,
  output adc_tick_t tick_o
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(DIV - 1);
  localparam logic [PW-1:0] PH_FALL = PW'(DIV / 2 - 1);

  logic [PW-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst)                ph <= '0;
    else if (ph == PH_LAST) ph <= '0;
    else                    ph <= ph + 1'b1;
  end

  always_comb begin
    tick_o.rise = (ph == PH_LAST);
    tick_o.fall = (ph == PH_FALL);
  end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int RES_W    = 10,
  parameter int SEL_W    = 5,
  parameter int NORM_CYC = 13,
  parameter int EXT_CYC  = 25,
  localparam int IW      = $clog2(RES_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             free_i,
  input  logic             start_q_i,
  input  logic [SEL_W-1:0] sel_i,
  input  adc_tick_t        tick_i,
  output logic             strobe_o,
  output logic             load_o,
  output logic             step_o,
  output logic [IW-1:0]    bit_idx_o,
  output logic             done_o,
  output logic [SEL_W-1:0] mux_sel_o
);
  localparam int CW = $clog2(EXT_CYC + 1);
  localparam int SMP_E_INT = ext_sample_cycle(NORM_CYC, EXT_CYC);
  localparam logic [CW-1:0] LEN_N  = CW'(NORM_CYC);
  localparam logic [CW-1:0] LEN_E  = CW'(EXT_CYC);
  localparam logic [CW-1:0] SMP_N  = CW'(NORM_SAMPLE);
  localparam logic [CW-1:0] SMP_E  = CW'(SMP_E_INT);
  localparam logic [CW-1:0] LAST_N = CW'(NORM_SAMPLE + RES_W - 1);
  localparam logic [CW-1:0] LAST_E = CW'(SMP_E_INT + RES_W - 1);
  localparam logic [CW-1:0] CYC1   = CW'(1);

  logic          busy, ext, ext_pend;
  logic [CW-1:0] cyc;
  logic [CW-1:0] len, smp, last;
  logic          at_end, in_sar, at_smp;

  always_comb begin
    len    = ext ? LEN_E  : LEN_N;
    smp    = ext ? SMP_E  : SMP_N;
    last   = ext ? LAST_E : LAST_N;
    at_end = busy && (cyc == len);
    at_smp = busy && (cyc == smp);
    in_sar = busy && (cyc >= smp) && (cyc <= last);
    done_o    = en_i && tick_i.rise && at_end;
    load_o    = en_i && tick_i.fall && at_smp;
    step_o    = en_i && tick_i.rise && in_sar;
    bit_idx_o = IW'(RES_W - 1) - IW'(cyc - smp);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      ext       <= 1'b0;
      ext_pend  <= 1'b1;
      cyc       <= '0;
      strobe_o  <= 1'b0;
      mux_sel_o <= '0;
    end else begin
      strobe_o <= load_o;
      if (!en_i) begin
        busy     <= 1'b0;
        ext_pend <= 1'b1;
        cyc      <= '0;
      end else if (tick_i.rise) begin
        if (busy) begin
          if (at_end) begin
            if (free_i) begin
              cyc       <= CYC1;
              ext       <= 1'b0;
              mux_sel_o <= sel_i;
            end else begin
              busy <= 1'b0;
              cyc  <= '0;
            end
          end else begin
            cyc <= cyc + 1'b1;
          end
        end else if (start_q_i) begin
          busy      <= 1'b1;
          cyc       <= CYC1;
          ext       <= ext_pend;
          ext_pend  <= 1'b0;
          mux_sel_o <= sel_i;
        end
      end
    end
  end
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
  parameter int RES_W = 10,
  localparam int IW   = $clog2(RES_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [IW-1:0]    bit_idx_i,
  input  logic             comp_i,
  output logic [RES_W-1:0] code_o
);
  for (genvar i = 0; i < RES_W; i++) begin : g_bit
    localparam logic [IW-1:0] ME   = IW'(i);
    localparam logic [IW-1:0] UPPR = IW'(i + 1);
    always_ff @(posedge clk) begin
      if (rst)
        code_o[i] <= 1'b0;
      else if (load_i)
        code_o[i] <= (i == RES_W - 1);
      else if (step_i && bit_idx_i == ME)
        code_o[i] <= comp_i;
      else if (step_i && (i < RES_W - 1) && bit_idx_i == UPPR)
        code_o[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/sar_status.sv
module sar_status #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             free_i,
  input  logic             start_wr_i,
  input  logic             start_wd_i,
  input  logic             flag_clr_i,
  input  logic             done_i,
  input  logic [RES_W-1:0] code_i,
  output logic             start_q_o,
  output logic             flag_o,
  output logic [RES_W-1:0] result_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      start_q_o <= 1'b0;
      flag_o    <= 1'b0;
      result_o  <= '0;
    end else begin
      if (!en_i)                          start_q_o <= 1'b0;
      else if (start_wr_i && start_wd_i)  start_q_o <= 1'b1;
      else if (done_i && !free_i)         start_q_o <= 1'b0;

      if (done_i) begin
        flag_o   <= 1'b1;
        result_o <= code_i;
      end else if (flag_clr_i) begin
        flag_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int DIV      = 4,
  parameter int RES_W    = 10,
  parameter int SEL_W    = 5,
  parameter int NORM_CYC = 13,
  parameter int EXT_CYC  = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             free_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             start_wr_i,
  input  logic             start_wd_i,
  input  logic             flag_clr_i,
  input  logic             comp_i,
  output logic             sh_strobe_o,
  output logic [RES_W-1:0] dac_code_o,
  output logic [RES_W-1:0] result_o,
  output logic             done_flag_o,
  output logic             start_o,
  output logic [SEL_W-1:0] mux_sel_o
);
  localparam int IW = $clog2(RES_W);

  adc_tick_t     tick;
  logic          load, step, done;
  logic [IW-1:0] bit_idx;

  sar_tick_gen #(.DIV(DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  sar_seq_ctrl #(
    .RES_W(RES_W), .SEL_W(SEL_W), .NORM_CYC(NORM_CYC), .EXT_CYC(EXT_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .en_i      (en_i),
    .free_i    (free_i),
    .start_q_i (start_o),
    .sel_i     (sel_i),
    .tick_i    (tick),
    .strobe_o  (sh_strobe_o),
    .load_o    (load),
    .step_o    (step),
    .bit_idx_o (bit_idx),
    .done_o    (done),
    .mux_sel_o (mux_sel_o)
  );

  sar_approx_reg #(.RES_W(RES_W)) u_sar (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load),
    .step_i    (step),
    .bit_idx_i (bit_idx),
    .comp_i    (comp_i),
    .code_o    (dac_code_o)
  );

  sar_status #(.RES_W(RES_W)) u_stat (
    .clk        (clk),
    .rst        (rst),
    .en_i       (en_i),
    .free_i     (free_i),
    .start_wr_i (start_wr_i),
    .start_wd_i (start_wd_i),
    .flag_clr_i (flag_clr_i),
    .done_i     (done),
    .code_i     (dac_code_o),
    .start_q_o  (start_o),
    .flag_o     (done_flag_o),
    .result_o   (result_o)
  );
endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
  parameter int SEL_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             en_i,
  input logic             free_i,
  input logic             start_wr_i,
  input logic             start_wd_i,
  input logic             flag_clr_i,
  input logic             sh_strobe_o,
  input logic             done_flag_o,
  input logic             start_o,
  input logic [SEL_W-1:0] mux_sel_o
);
  p_strobe_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    sh_strobe_o |=> !sh_strobe_o);

  p_strobe_in_conv_r5: assert property (@(posedge clk) disable iff (rst)
    sh_strobe_o |-> start_o);

  p_single_clear_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(done_flag_o) && !$past(free_i) && !$past(start_wr_i && start_wd_i))
      |-> !start_o);

  p_free_keep_r8: assert property (@(posedge clk) disable iff (rst)
    ($rose(done_flag_o) && $past(free_i)) |-> start_o);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (done_flag_o && !flag_clr_i) |=> done_flag_o);

  p_disable_clear_r11: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !start_o);

  p_sel_latch_r12: assert property (@(posedge clk) disable iff (rst)
    !$stable(mux_sel_o) |-> $past(start_o));
endmodule

bind sar_conv_seq sar_conv_seq_chk #(.SEL_W(SEL_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .en_i        (en_i),
  .free_i      (free_i),
  .start_wr_i  (start_wr_i),
  .start_wd_i  (start_wd_i),
  .flag_clr_i  (flag_clr_i),
  .sh_strobe_o (sh_strobe_o),
  .done_flag_o (done_flag_o),
  .start_o     (start_o),
  .mux_sel_o   (mux_sel_o)
);

// File: tb/tb_sar_conv_seq.sv
module tb_sar_conv_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 4;
  localparam int RES_W = 10;
  localparam int SEL_W = 5;
  localparam int NC    = 13;
  localparam int EC    = 25;
  localparam int NCODE = 1 << RES_W;

  // expected distances in system clocks
  localparam int SMP_TO_DONE = (NC - 2 + 1) * DIV - DIV / 2;
  localparam int WR_SMP_N    = (2 - 1) * DIV + DIV / 2;
  localparam int WR_SMP_E    = (EC - NC + 2 - 1) * DIV + DIV / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, free_m = 1'b0, swr = 1'b0, swd = 1'b0, fclr = 1'b0;
  logic [SEL_W-1:0] sel = '0;
  logic [RES_W-1:0] vin = '0, held = '0;
  logic comp;
  logic sh_strobe, done_flag, start_rb;
  logic [RES_W-1:0] dac_code, result;
  logic [SEL_W-1:0] mux_sel;

  int checks = 0, errors = 0, tcnt = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) tcnt <= tcnt + 1;

  // comparator and sample-and-hold model
  always @(posedge clk) if (sh_strobe) held <= vin;
  assign comp = (held >= dac_code);

  sar_conv_seq #(.DIV(DIV), .RES_W(RES_W), .SEL_W(SEL_W), .NORM_CYC(NC), .EXT_CYC(EC)) dut (
    .clk(clk), .rst(rst), .en_i(en), .free_i(free_m), .sel_i(sel),
    .start_wr_i(swr), .start_wd_i(swd), .flag_clr_i(fclr), .comp_i(comp),
    .sh_strobe_o(sh_strobe), .dac_code_o(dac_code), .result_o(result),
    .done_flag_o(done_flag), .start_o(start_rb), .mux_sel_o(mux_sel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr_start(input bit d, output int t);
    @(negedge clk); swr = 1'b1; swd = d;
    @(negedge clk); swr = 1'b0; swd = 1'b0;
    t = tcnt;
  endtask

  task automatic clr_flag();
    @(negedge clk); fclr = 1'b1;
    @(negedge clk); fclr = 1'b0;
  endtask

  // polls until the flag is seen; records strobe time and start level before
  task automatic wait_done(output int td, output int ts, output bit sb);
    int n = 0;
    bit seen = 1'b0;
    ts = -1; sb = 1'b0;
    while (!seen && n < 2000) begin
      @(negedge clk);
      if (sh_strobe) ts = tcnt;
      if (done_flag) seen = 1'b1;
      else sb = start_rb;
      n++;
    end
    td = tcnt;
    if (!seen) chk(1'b0, "R3 completion timeout", n, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (R3): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int twr, td, ts, tprev;
    bit sb;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk(!start_rb && !done_flag && !sh_strobe, "R1 control outputs", {start_rb, done_flag, sh_strobe}, 0);
    chk(result == 0 && dac_code == 0, "R1 codes", int'(result) + int'(dac_code), 0);
    chk(mux_sel == 0, "R1 mux select", mux_sel, 0);

    // first conversion after enable: extended, single mode
    en = 1'b1; free_m = 1'b0; sel = 5'd3; vin = 10'h2A5;
    wr_start(1'b1, twr);
    wait_done(td, ts, sb);
    chk_rng("R4 extended length", td - twr, EC * DIV + 1, EC * DIV + DIV);
    chk_rng("R2 R5 extended strobe offset", ts - twr, WR_SMP_E + 1, WR_SMP_E + DIV);
    chk(td - ts == SMP_TO_DONE, "R5 strobe to done", td - ts, SMP_TO_DONE);
    chk(result == 10'h2A5, "R6 result", result, 10'h2A5);
    chk(sb && !start_rb, "R7 start clears with flag", {sb, start_rb}, 2);
    chk(mux_sel == 5'd3, "R12 latched select", mux_sel, 3);
    repeat (20) @(negedge clk);
    chk(done_flag == 1'b1, "R9 flag sticky", done_flag, 1);
    clr_flag();
    @(negedge clk);
    chk(done_flag == 1'b0, "R9 flag cleared", done_flag, 0);

    // normal single conversion
    vin = 10'h155;
    wr_start(1'b1, twr);
    wait_done(td, ts, sb);
    chk_rng("R3 normal length", td - twr, NC * DIV + 1, NC * DIV + DIV);
    chk_rng("R2 R5 normal strobe offset", ts - twr, WR_SMP_N + 1, WR_SMP_N + DIV);
    chk(td - ts == SMP_TO_DONE, "R5 strobe to done", td - ts, SMP_TO_DONE);
    chk(result == 10'h155, "R6 result", result, 10'h155);
    chk(sb && !start_rb, "R7 start clears with flag", {sb, start_rb}, 2);
    clr_flag();

    // write of 0 and select change during a conversion
    vin = 10'h3FF;
    wr_start(1'b1, twr);
    repeat (10) @(negedge clk);
    sel = 5'd7;
    wr_start(1'b0, twr);
    @(negedge clk);
    chk(start_rb == 1'b1, "R10 write 0 ignored", start_rb, 1);
    chk(mux_sel == 5'd3, "R12 select held mid conversion", mux_sel, 3);
    wait_done(td, ts, sb);
    chk(result == 10'h3FF, "R10 conversion completes", result, 10'h3FF);
    chk(mux_sel == 5'd3, "R12 select held to end", mux_sel, 3);
    clr_flag();
    vin = 10'h000;
    wr_start(1'b1, twr);
    wait_done(td, ts, sb);
    chk(mux_sel == 5'd7, "R12 new select at next start", mux_sel, 7);
    chk(result == 10'h000, "R6 zero code", result, 0);
    clr_flag();

    // abort by disabling
    vin = 10'h100;
    wr_start(1'b1, twr);
    repeat (20) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(start_rb == 1'b0, "R11 disable clears start", start_rb, 0);
    wr_start(1'b1, twr);
    repeat (120) @(negedge clk);
    chk(done_flag == 1'b0 && start_rb == 1'b0, "R11 aborted, writes ignored", {done_flag, start_rb}, 0);
    en = 1'b1; vin = 10'h0CC;
    wr_start(1'b1, twr);
    wait_done(td, ts, sb);
    chk_rng("R11 R4 extended after re-enable", td - twr, EC * DIV + 1, EC * DIV + DIV);
    chk(result == 10'h0CC, "R6 result after abort", result, 10'h0CC);
    clr_flag();

    // free-running sweep over every code
    free_m = 1'b1; vin = '0; sel = '0;
    wr_start(1'b1, twr);
    tprev = 0;
    for (int v = 0; v < NCODE; v++) begin
      wait_done(td, ts, sb);
      chk(result == RES_W'(v), "R6 sweep result", result, v);
      chk(mux_sel == SEL_W'(v), "R12 sweep select", mux_sel, v % (1 << SEL_W));
      chk(start_rb == 1'b1, "R8 start stays set", start_rb, 1);
      chk(td - ts == SMP_TO_DONE, "R5 free strobe to done", td - ts, SMP_TO_DONE);
      if (v == 0) chk_rng("R3 first free length", td - twr, NC * DIV + 1, NC * DIV + DIV);
      else        chk(td - tprev == NC * DIV, "R3 R8 back-to-back period", td - tprev, NC * DIV);
      tprev = td;
      vin = RES_W'(v + 1); sel = SEL_W'(v + 1); fclr = 1'b1;
      @(negedge clk); fclr = 1'b0;
    end

    // leave free-running: the running conversion ends in single mode
    free_m = 1'b0;
    wait_done(td, ts, sb);
    chk(sb && !start_rb, "R7 start clears after leaving free mode", {sb, start_rb}, 2);
    chk(result == 10'h000, "R6 wrapped code", result, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule